// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block remembers which speculatively hoisted loads are still trustworthy. When a load is moved above earlier stores, it records an entry here. The entry is keyed by the register that the load writes, and it holds a few low bits of the physical address the load read. Every store that executes afterwards compares its own partial address against all live entries at once and kills the entries it may have overwritten.

Later, a verify operation names the same register. The verify operation learns in the same cycle whether the hoisted value can be kept. If it cannot, the consumer must run its recovery path.

The table has 32 entries, selected by the low five bits of the register identifier. The remaining identifier bits are stored in the entry and must match on lookup. A flush input empties the whole table in one cycle.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is empty, so a verify of any register identifier reports a miss.
- R2: A load with `ldValid` high writes the entry selected by `ldRegId[4:0]`. A verify of the same full identifier in any later cycle hits, as long as nothing has removed the entry.
- R3: A verify hits only when the stored identifier matches all `REG_W` bits. If only the low five bits agree, the result is a miss.
- R4: A newer load to an occupied entry index replaces the older entry. The old identifier then misses and the new one hits.
- R5: A store with `stValid` high invalidates, at the next clock edge, every valid entry whose stored tag equals `stTag`. This comparison covers all entries in parallel. Entries whose tag differs are left untouched.
- R6: The verify result is combinational, in the same cycle as `chkValid`. It reflects the table as it stood before that cycle's updates.
- R7: `chkFail` equals `chkValid` and not hit. While `chkValid` is low, both `chkHit` and `chkFail` are 0.
- R8: A verify with `chkClear` high that hits removes its entry at the clock edge. A verify with `chkClear` low leaves the entry in place.
- R9: When a load and a store-invalidation or a clearing verify target the same entry in one cycle, the load wins and the entry holds the new load.
- R10: `flushAll` empties every entry at the next edge. It takes priority over a load issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Empty the whole table |
| ldValid | input | 1 | Speculative load records an entry |
| ldRegId | input | REG_W (7) | Destination register of the load |
| ldTag | input | TAG_W (8) | Partial physical address of the load |
| stValid | input | 1 | A store executes |
| stTag | input | TAG_W (8) | Partial physical address of the store |
| chkValid | input | 1 | Verify operation present |
| chkRegId | input | REG_W (7) | Register named by the verify |
| chkClear | input | 1 | Remove the entry when the verify hits |
| chkHit | output | 1 | Hoisted value is still good |
| chkFail | output | 1 | Recovery required |

## Verification
The hardest situation to create is a single store that wipes several entries at once, while other entries that share an identifier alias stay valid. To reach it, the stimulus loads all 32 entries with tags that repeat every 16 entries and with high identifier bits that rotate. Selected stores then kill two entries each. After each such store, the bench sweeps a verify over all 128 identifiers to confirm that exactly the expected entries remain. Same-cycle collisions are driven directly: a load together with a matching store, a load together with a clearing verify, and a load together with a flush. In the collision cases, the verify in that same cycle must still see the old contents.

// File: rtl/specload_pkg.sv
package specload_pkg;
  localparam int ENTRY_CNT = 32;
  localparam int IDX_W     = $clog2(ENTRY_CNT);

  // strobes from control to storage
  typedef struct packed {
    logic                 wipeAll;
    logic                 allocEn;
    logic [IDX_W-1:0]     allocIdx;
    logic [ENTRY_CNT-1:0] dropMask;
  } tblCmd_t;
endpackage

// File: rtl/specload_store.sv
module specload_store
  import specload_pkg::*;
#(
  parameter int REG_W = 7,
  parameter int TAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tblCmd_t              cmd,
  input  logic [REG_W-1:0]     ldRegId,
  input  logic [TAG_W-1:0]     ldTag,
  input  logic [TAG_W-1:0]     stTag,
  input  logic [REG_W-1:0]     chkRegId,
  output logic [ENTRY_CNT-1:0] stMatch,
  output logic                 lookHit
);
  localparam int HI_W = REG_W - IDX_W;

  logic [ENTRY_CNT-1:0] validQ;
  logic [HI_W-1:0]      hiQ  [ENTRY_CNT];
  logic [TAG_W-1:0]     tagQ [ENTRY_CNT];
  logic [ENTRY_CNT-1:0] allocVec;

  // parallel tag comparators, one per entry
  for (genvar e = 0; e < ENTRY_CNT; e++) begin : g_cmp
    assign stMatch[e]  = validQ[e] && (tagQ[e] == stTag);
    assign allocVec[e] = cmd.allocEn && (cmd.allocIdx == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRY_CNT; e++) begin
      if (!rstN || cmd.wipeAll) begin
        validQ[e] <= 1'b0;
        if (!rstN) begin
          hiQ[e]  <= '0;
          tagQ[e] <= '0;
        end
      end else if (allocVec[e]) begin
        validQ[e] <= 1'b1;
        hiQ[e]    <= ldRegId[REG_W-1:IDX_W];
        tagQ[e]   <= ldTag;
      end else if (cmd.dropMask[e]) begin
        validQ[e] <= 1'b0;
      end
    end
  end

  logic [IDX_W-1:0] chkIdx;
  assign chkIdx  = chkRegId[IDX_W-1:0];
  assign lookHit = validQ[chkIdx] && (hiQ[chkIdx] == chkRegId[REG_W-1:IDX_W]);

  // R10
  wipe_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wipeAll |=> (validQ == '0));

  // R5
  drop_applied_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.wipeAll && (cmd.dropMask != '0)) |=>
      ((validQ & $past(cmd.dropMask) & ~$past(allocVec)) == '0));

  // R9
  alloc_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.allocEn && !cmd.wipeAll) |=> validQ[$past(cmd.allocIdx)]);
endmodule

// File: rtl/specload_ctrl.sv
module specload_ctrl
  import specload_pkg::*;
#(
  parameter int REG_W = 7
) (
  input  logic                 flushAll,
  input  logic                 ldValid,
  input  logic [REG_W-1:0]     ldRegId,
  input  logic                 stValid,
  input  logic [ENTRY_CNT-1:0] stMatch,
  input  logic                 chkValid,
  input  logic [REG_W-1:0]     chkRegId,
  input  logic                 chkClear,
  input  logic                 lookHit,
  output tblCmd_t              cmd,
  output logic                 chkHit,
  output logic                 chkFail
);
  logic [ENTRY_CNT-1:0] consumeVec;

  always_comb begin
    consumeVec = '0;
    if (chkValid && chkClear && lookHit)
      consumeVec[chkRegId[IDX_W-1:0]] = 1'b1;
  end

  always_comb begin
    cmd.wipeAll  = flushAll;
    cmd.allocEn  = ldValid;
    cmd.allocIdx = ldRegId[IDX_W-1:0];
    cmd.dropMask = (stValid ? stMatch : '0) | consumeVec;
  end

  assign chkHit  = chkValid && lookHit;
  assign chkFail = chkValid && !lookHit;
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import specload_pkg::*;
#(
  parameter int REG_W = 7,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushAll,
  input  logic             ldValid,
  input  logic [REG_W-1:0] ldRegId,
  input  logic [TAG_W-1:0] ldTag,
  input  logic             stValid,
  input  logic [TAG_W-1:0] stTag,
  input  logic             chkValid,
  input  logic [REG_W-1:0] chkRegId,
  input  logic             chkClear,
  output logic             chkHit,
  output logic             chkFail
);
  tblCmd_t              cmd;
  logic [ENTRY_CNT-1:0] stMatch;
  logic                 lookHit;

  specload_ctrl #(.REG_W(REG_W)) u_ctrl (
    .flushAll(flushAll), .ldValid(ldValid), .ldRegId(ldRegId),
    .stValid(stValid), .stMatch(stMatch), .chkValid(chkValid),
    .chkRegId(chkRegId), .chkClear(chkClear), .lookHit(lookHit),
    .cmd(cmd), .chkHit(chkHit), .chkFail(chkFail)
  );

  specload_store #(.REG_W(REG_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ldRegId(ldRegId), .ldTag(ldTag),
    .stTag(stTag), .chkRegId(chkRegId), .stMatch(stMatch), .lookHit(lookHit)
  );

  // R2
  load_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !flushAll) |=>
      (!chkValid || (chkRegId != $past(ldRegId)) || chkHit));

  // R8
  clear_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkClear && chkHit && !flushAll &&
     !(ldValid && (ldRegId[IDX_W-1:0] == chkRegId[IDX_W-1:0]))) |=>
      (!chkValid || (chkRegId != $past(chkRegId)) || !chkHit));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !chkHit);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> (!chkHit && !chkFail));
endmodule

// File: tb/spec_load_table_tb.sv
module spec_load_table_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushAll = 0, ldValid = 0, stValid = 0, chkValid = 0, chkClear = 0;
  logic [6:0] ldRegId = '0, chkRegId = '0;
  logic [7:0] ldTag = '0, stTag = '0;
  logic chkHit, chkFail;

  always #10 clk = ~clk;

  spec_load_table u_dut (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .ldValid(ldValid),
    .ldRegId(ldRegId), .ldTag(ldTag), .stValid(stValid), .stTag(stTag),
    .chkValid(chkValid), .chkRegId(chkRegId), .chkClear(chkClear),
    .chkHit(chkHit), .chkFail(chkFail)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit       mValid [32];
  bit [6:0] mReg   [32];
  bit [7:0] mTag   [32];

  task automatic step(input bit fl, input bit ld, input bit [6:0] lr, input bit [7:0] lt,
                      input bit st, input bit [7:0] stt,
                      input bit cv, input bit [6:0] cr, input bit cc, input string req);
    bit expHit;
    int ci;
    @(negedge clk);
    flushAll = fl; ldValid = ld; ldRegId = lr; ldTag = lt;
    stValid = st; stTag = stt; chkValid = cv; chkRegId = cr; chkClear = cc;
    #5;
    ci = int'(cr[4:0]);
    expHit = cv && mValid[ci] && (mReg[ci] == cr);
    checks++;
    if (chkHit !== expHit || chkFail !== (cv && !expHit)) begin
      errors++;
      $display("FAIL %s reg=%0d hit=%b fail=%b expected hit=%b fail=%b",
               req, cr, chkHit, chkFail, expHit, cv && !expHit);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 32; i++) begin
      if (fl) mValid[i] = 0;
      else if (ld && int'(lr[4:0]) == i) begin
        mValid[i] = 1; mReg[i] = lr; mTag[i] = lt;
      end else if ((st && mValid[i] && mTag[i] == stt) || (cc && expHit && ci == i))
        mValid[i] = 0;
    end
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 128; r++) step(0, 0, 0, 0, 0, 0, 1, 7'(r), 0, req);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mValid[i] = 0; mReg[i] = 0; mTag[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: every identifier misses after reset
    sweep("R1");
    // R2 / R3: fill all entries, high bits rotate, tags repeat every 16
    for (int i = 0; i < 32; i++)
      step(0, 1, 7'(i + 32 * (i % 4)), 8'((i * 3) % 48), 0, 0, 0, 0, 0, "R2");
    sweep("R3");
    // R4: overwrite entry 5 with another identifier
    step(0, 1, 7'(5 + 64), 8'd200, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 7'(5 + 32), 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 7'(5 + 64), 0, "R4");
    // R5: stores that kill two entries each, with a sweep after each
    for (int t = 0; t < 4; t++) begin
      step(0, 0, 0, 0, 1, 8'(t * 3), 0, 0, 0, "R5");
      sweep("R5");
    end
    step(0, 0, 0, 0, 1, 8'd250, 0, 0, 0, "R5");
    sweep("R5");
    // R6: a verify in the load's cycle sees the old state, the next one the new state
    step(0, 1, 7'd1, 8'd77, 0, 0, 1, 7'd1, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 7'd1, 0, "R6");
    // R8: a plain verify keeps the entry, a clearing verify consumes it
    step(0, 0, 0, 0, 0, 0, 1, 7'd1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 7'd1, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 7'd1, 0, "R8");
    // R7: outputs quiet without a verify
    step(0, 1, 7'd2, 8'd9, 0, 0, 0, 7'd2, 0, "R7");
    // R9: a load plus a matching store on the same entry
    step(0, 1, 7'd34, 8'd9, 1, 8'd9, 1, 7'd2, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 7'd34, 0, "R9");
    step(0, 1, 7'd98, 8'd4, 0, 0, 1, 7'd34, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 7'd98, 0, "R9");
    // R10: flush beats a load in the same cycle
    step(1, 1, 7'd3, 8'd1, 0, 0, 1, 7'd98, 0, "R10");
    sweep("R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule